// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block takes up to 32 interrupt request lines and sorts them onto two outputs. Each line either goes to a fast interrupt output, which has no vector, or to a normal interrupt output, which is served through a handler address. Every line has a mask bit and a steering bit. Sixteen programmable slots each name one source line and hold a handler address for it. A default address covers normal-interrupt lines that no enabled slot names.

Software sets up the controller through a simple word-addressed register bus. The interrupt entry code then reads the current-vector register to get a handler address. That read marks the winning request as in service. While the request is in service, every read of the register returns the same address. A write to the register ends service. Incoming lines are sampled once on each clock, so both outputs and the vector follow the lines one cycle later.

Top module: `vecIntCtrl`

## Requirements
- R1: After reset, the line masks, the steering bits and the slot enables are all zero, so `irqOut` and `fiqOut` stay low whatever the lines do.
- R2: A line whose mask bit (register 0x00, bit n for line n) is zero contributes to neither output and never produces a vector.
- R3: A masked-in line whose steering bit (register 0x01, 1 = fast) is set drives `fiqOut`. `fiqOut` is the OR of all such pending lines, and fast lines are never claimed by a slot.
- R4: `irqOut` is the OR of all pending lines that are masked in and have a steering bit of 0.
- R5: Slot s has an address register at 0x10+s and a control register at 0x20+s (bits 4:0 source line, bit 5 enable). An enabled slot whose source is a pending normal-interrupt line supplies its address on a read of the current-vector register at 0x03.
- R6: When several enabled slots have pending sources, the lowest-numbered slot supplies the vector.
- R7: When no enabled slot has a pending source, the vector read returns the default address (register 0x02). This covers the case where no normal interrupt is pending at all, and also a slot that is disabled or names a fast line.
- R8: Line 31 is reserved (parameter mask). It never asserts either output, and it never lets a slot win.
- R9: A vector read while a normal interrupt is pending latches the returned address as in service. Later reads return that address until a write to 0x03 ends service. A read with nothing pending latches nothing.
- R10: The mask, steering, default, slot address and slot control registers read back the values written to them.
- R11: Outputs and the vector reflect the lines as sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on the vector register) |
| regAddr | input | 8 | Word register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, combinational from regAddr |
| irqLines | input | NUM_LINES | Interrupt request lines, active high |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench targets slot ordering when two claimed lines are pending. A reversed priority chain would return the higher slot's address. It also checks that a disabled slot, and a slot naming a fast line, fall through to the default address; a design that ignored the slot enable or the steering bit would hand out a slot address there. It holds a request in service while a higher-priority line arrives, which exposes a design that re-arbitrates on every read. Finally, it drives the reserved line and masked lines, where a missing mask would raise an output.

// File: rtl/vicPkg.sv
package vicPkg;

  localparam logic [7:0] REG_LINE_EN = 8'h00;
  localparam logic [7:0] REG_SELECT  = 8'h01;
  localparam logic [7:0] REG_DEFAULT = 8'h02;
  localparam logic [7:0] REG_VECTOR  = 8'h03;
  localparam logic [3:0] PAGE_SLOT_ADDR = 4'h1;
  localparam logic [3:0] PAGE_SLOT_CTRL = 4'h2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LINE_EN,
    SEL_SELECT,
    SEL_DEFAULT,
    SEL_VECTOR,
    SEL_SLOT_ADDR,
    SEL_SLOT_CTRL
  } rdSelT;

  typedef struct packed {
    logic       wrLineEn;
    logic       wrSelect;
    logic       wrDefault;
    logic       wrSlotAddr;
    logic       wrSlotCtrl;
    logic       vecRead;
    logic       vecDone;
    logic [3:0] slotIdx;
    rdSelT      rdSel;
  } vicStrobeT;

endpackage

// File: rtl/vicCtrl.sv
module vicCtrl
  import vicPkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regAddr,
  output vicStrobeT  strobe
);

  logic slotOk;
  assign slotOk = ({1'b0, regAddr[3:0]} < 5'(NUM_SLOTS));

  always_comb begin
    strobe.wrLineEn   = 1'b0;
    strobe.wrSelect   = 1'b0;
    strobe.wrDefault  = 1'b0;
    strobe.wrSlotAddr = 1'b0;
    strobe.wrSlotCtrl = 1'b0;
    strobe.vecRead    = 1'b0;
    strobe.vecDone    = 1'b0;
    strobe.slotIdx    = regAddr[3:0];
    strobe.rdSel      = SEL_NONE;
    if (regAddr == REG_LINE_EN) begin
      strobe.rdSel    = SEL_LINE_EN;
      strobe.wrLineEn = regWrEn;
    end else if (regAddr == REG_SELECT) begin
      strobe.rdSel    = SEL_SELECT;
      strobe.wrSelect = regWrEn;
    end else if (regAddr == REG_DEFAULT) begin
      strobe.rdSel     = SEL_DEFAULT;
      strobe.wrDefault = regWrEn;
    end else if (regAddr == REG_VECTOR) begin
      strobe.rdSel   = SEL_VECTOR;
      strobe.vecRead = regRdEn;
      strobe.vecDone = regWrEn;
    end else if (regAddr[7:4] == PAGE_SLOT_ADDR && slotOk) begin
      strobe.rdSel      = SEL_SLOT_ADDR;
      strobe.wrSlotAddr = regWrEn;
    end else if (regAddr[7:4] == PAGE_SLOT_CTRL && slotOk) begin
      strobe.rdSel      = SEL_SLOT_CTRL;
      strobe.wrSlotCtrl = regWrEn;
    end
  end

endmodule

// File: rtl/vicDatapath.sv
module vicDatapath
  import vicPkg::*;
#(
  parameter int                   NUM_LINES     = 32,
  parameter int                   NUM_SLOTS     = 16,
  parameter int                   ADDR_W        = 32,
  parameter int                   DATA_W        = 32,
  parameter logic [NUM_LINES-1:0] RESERVED_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vicStrobeT            strobe,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut,
  output logic                 fiqOut,
  output logic [NUM_LINES-1:0] lineEnQ,
  output logic [NUM_LINES-1:0] fastSelQ,
  output logic [NUM_LINES-1:0] sampledQ,
  output logic                 inSvcQ,
  output logic [ADDR_W-1:0]    svcAddrQ
);

  localparam int SRC_W  = $clog2(NUM_LINES);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic [ADDR_W-1:0]    defAddrQ;
  logic [ADDR_W-1:0]    slotAddrQ [NUM_SLOTS];
  logic [SRC_W-1:0]     slotSrcQ  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotOnQ;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [NUM_LINES-1:0] activeIrq;
  logic [NUM_LINES-1:0] activeFiq;
  logic [ADDR_W-1:0]    winAddr;
  logic [SLOT_W-1:0]    idx;

  assign idx = SLOT_W'(strobe.slotIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineEnQ  <= '0;
      fastSelQ <= '0;
      defAddrQ <= '0;
      sampledQ <= '0;
    end else begin
      sampledQ <= irqLines;
      if (strobe.wrLineEn)  lineEnQ  <= regWrData[NUM_LINES-1:0];
      if (strobe.wrSelect)  fastSelQ <= regWrData[NUM_LINES-1:0];
      if (strobe.wrDefault) defAddrQ <= regWrData[ADDR_W-1:0];
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddrQ[s] <= '0;
        slotSrcQ[s]  <= '0;
        slotOnQ[s]   <= 1'b0;
      end else if (idx == SLOT_W'(s)) begin
        if (strobe.wrSlotAddr) slotAddrQ[s] <= regWrData[ADDR_W-1:0];
        if (strobe.wrSlotCtrl) begin
          slotSrcQ[s] <= regWrData[SRC_W-1:0];
          slotOnQ[s]  <= regWrData[SRC_W];
        end
      end
    end
    assign slotHit[s] = slotOnQ[s] & activeIrq[slotSrcQ[s]];
  end

  assign activeIrq = sampledQ & lineEnQ & ~fastSelQ & ~RESERVED_MASK;
  assign activeFiq = sampledQ & lineEnQ & fastSelQ & ~RESERVED_MASK;
  assign irqOut    = |activeIrq;
  assign fiqOut    = |activeFiq;

  // Walk from the highest slot down so the lowest hit is applied last.
  always_comb begin
    winAddr = defAddrQ;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slotHit[s]) winAddr = slotAddrQ[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvcQ   <= 1'b0;
      svcAddrQ <= '0;
    end else if (strobe.vecDone) begin
      inSvcQ <= 1'b0;
    end else if (strobe.vecRead && !inSvcQ && irqOut) begin
      inSvcQ   <= 1'b1;
      svcAddrQ <= winAddr;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_LINE_EN:   regRdData = DATA_W'(lineEnQ);
      SEL_SELECT:    regRdData = DATA_W'(fastSelQ);
      SEL_DEFAULT:   regRdData = DATA_W'(defAddrQ);
      SEL_VECTOR:    regRdData = DATA_W'(inSvcQ ? svcAddrQ : winAddr);
      SEL_SLOT_ADDR: regRdData = DATA_W'(slotAddrQ[idx]);
      SEL_SLOT_CTRL: regRdData = DATA_W'({slotOnQ[idx], slotSrcQ[idx]});
      default:       regRdData = '0;
    endcase
  end

endmodule

// File: rtl/vecIntCtrl.sv
module vecIntCtrl
  import vicPkg::*;
#(
  parameter int                   NUM_LINES     = 32,
  parameter int                   NUM_SLOTS     = 16,
  parameter int                   ADDR_W        = 32,
  parameter int                   DATA_W        = 32,
  parameter logic [NUM_LINES-1:0] RESERVED_MASK = 32'h8000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [7:0]           regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic                 irqOut,
  output logic                 fiqOut
);

  vicStrobeT            strobe;
  logic [NUM_LINES-1:0] lineEnQ;
  logic [NUM_LINES-1:0] fastSelQ;
  logic [NUM_LINES-1:0] sampledQ;
  logic                 inSvcQ;
  logic [ADDR_W-1:0]    svcAddrQ;

  vicCtrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  vicDatapath #(
    .NUM_LINES     (NUM_LINES),
    .NUM_SLOTS     (NUM_SLOTS),
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .RESERVED_MASK (RESERVED_MASK)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .irqLines  (irqLines),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut),
    .lineEnQ   (lineEnQ),
    .fastSelQ  (fastSelQ),
    .sampledQ  (sampledQ),
    .inSvcQ    (inSvcQ),
    .svcAddrQ  (svcAddrQ)
  );

endmodule

// File: rtl/vecIntCtrlChk.sv
module vecIntCtrlChk
  import vicPkg::*;
#(
  parameter int                   NUM_LINES     = 32,
  parameter int                   ADDR_W        = 32,
  parameter int                   DATA_W        = 32,
  parameter logic [NUM_LINES-1:0] RESERVED_MASK = '0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic                 regRdEn,
  input logic [7:0]           regAddr,
  input logic [DATA_W-1:0]    regRdData,
  input logic                 irqOut,
  input logic                 fiqOut,
  input logic [NUM_LINES-1:0] lineEnQ,
  input logic [NUM_LINES-1:0] fastSelQ,
  input logic [NUM_LINES-1:0] sampledQ,
  input logic                 inSvcQ,
  input logic [ADDR_W-1:0]    svcAddrQ
);

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sampledQ & lineEnQ) == '0) |-> (!irqOut && !fiqOut));

  // R3
  fiq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sampledQ & lineEnQ & fastSelQ) == '0) |-> !fiqOut);

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sampledQ & lineEnQ & ~fastSelQ) == '0) |-> !irqOut);

  // R8
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sampledQ & ~RESERVED_MASK) == '0) |-> (!irqOut && !fiqOut));

  // R9
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == REG_VECTOR && inSvcQ)
      |-> (regRdData == DATA_W'(svcAddrQ)));

  // R9
  svc_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_VECTOR) |=> !inSvcQ);

endmodule

bind vecIntCtrl vecIntCtrlChk #(
  .NUM_LINES     (NUM_LINES),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .RESERVED_MASK (RESERVED_MASK)
) chk (.*);

// File: tb/tb_vecIntCtrl.sv
`timescale 1ns/1ps
module tb_vecIntCtrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] irqLines = '0;
  logic        irqOut;
  logic        fiqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vecIntCtrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqLines(irqLines), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  localparam logic [31:0] DEF = 32'h0000_D000;

  // {lines, irq, fiq, vector}
  localparam logic [65:0] TAB [12] = '{
    {32'h0000_0000, 1'b0, 1'b0, DEF},
    {32'h0000_0008, 1'b1, 1'b0, 32'h0000_1100},
    {32'h0000_0408, 1'b1, 1'b0, 32'h0000_1000},
    {32'h0010_0000, 1'b1, 1'b0, DEF},
    {32'h0000_0020, 1'b0, 1'b1, DEF},
    {32'h0000_0010, 1'b0, 1'b1, DEF},
    {32'h0010_0010, 1'b1, 1'b1, DEF},
    {32'h0000_1000, 1'b0, 1'b0, DEF},
    {32'h8000_0000, 1'b0, 1'b0, DEF},
    {32'h0010_0008, 1'b1, 1'b0, 32'h0000_1100},
    {32'h0000_0001, 1'b1, 1'b0, DEF},
    {32'h0000_0018, 1'b1, 1'b1, 32'h0000_1100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    // R1: reset state with every line high
    irqLines = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 irqOut after reset", 32'(irqOut), 0);
    check("R1 fiqOut after reset", 32'(fiqOut), 0);
    rdReg(8'h00, d); check("R1 mask reg zero", d, 0);
    rdReg(8'h01, d); check("R1 steer reg zero", d, 0);
    rdReg(8'h20, d); check("R1 slot0 ctrl zero", d, 0);
    irqLines = '0;

    // configuration: line 12 masked, lines 4..7 fast
    wrReg(8'h00, 32'hFFFF_EFFF);
    wrReg(8'h01, 32'h0000_00F0);
    wrReg(8'h02, DEF);
    wrReg(8'h10, 32'h0000_1000); wrReg(8'h20, 32'h2A); // slot0 line10
    wrReg(8'h11, 32'h0000_1100); wrReg(8'h21, 32'h23); // slot1 line3
    wrReg(8'h12, 32'h0000_1200); wrReg(8'h22, 32'h24); // slot2 line4 (fast)
    wrReg(8'h13, 32'h0000_1300); wrReg(8'h23, 32'h14); // slot3 line20 disabled
    wrReg(8'h1F, 32'h0000_1F00); wrReg(8'h2F, 32'h3F); // slot15 line31
    rdReg(8'h00, d); check("R10 mask readback", d, 32'hFFFF_EFFF);
    rdReg(8'h01, d); check("R10 steer readback", d, 32'h0000_00F0);
    rdReg(8'h02, d); check("R10 default readback", d, DEF);
    rdReg(8'h20, d); check("R10 slot0 ctrl readback", d, 32'h2A);
    rdReg(8'h13, d); check("R10 slot3 addr readback", d, 32'h1300);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      irqLines = TAB[i][65:34];
      @(negedge clk);
      check($sformatf("R4 R11 irqOut entry %0d", i), 32'(irqOut), 32'(TAB[i][33]));
      check($sformatf("R3 R2 R8 fiqOut entry %0d", i), 32'(fiqOut), 32'(TAB[i][32]));
      rdReg(8'h03, d);
      check($sformatf("R5 R6 R7 vector entry %0d", i), d, TAB[i][31:0]);
      wrReg(8'h03, 32'h0);
    end

    // R9: in-service hold, then release
    @(negedge clk); irqLines = 32'h0000_0008;
    @(negedge clk);
    rdReg(8'h03, d); check("R9 first read", d, 32'h1100);
    irqLines = 32'h0000_0408;
    @(negedge clk);
    rdReg(8'h03, d); check("R9 held while in service", d, 32'h1100);
    wrReg(8'h03, 32'h0);
    rdReg(8'h03, d); check("R9 after service end", d, 32'h1000);
    wrReg(8'h03, 32'h0);

    // R9: read with nothing pending latches nothing
    irqLines = '0;
    repeat (2) @(negedge clk);
    rdReg(8'h03, d); check("R9 idle read default", d, DEF);
    irqLines = 32'h0000_0400;
    repeat (2) @(negedge clk);
    rdReg(8'h03, d); check("R9 no stale latch", d, 32'h1000);
    wrReg(8'h03, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule